// File: doc/BRIEF.md
# Page Buffer Occupancy and Source Throttle Controller

This block tracks how full a paged event buffer is and tells the upstream data source when to stop sending. Each cycle it can see two strobes. One marks a page taken from the free list and queued as used. The other marks a used page handed back to the free list. From these it keeps a count of used pages, and the free-page count follows from it.

The used count is compared against a bank of programmable occupancy levels. Each level has its own status bit. Separately, the free-page count drives a single one-way throttle line (XOFF) to the source, with hysteresis between a programmable low level and a programmable high level. XOFF also has two manual controls, both set from a small address/data register port:
- a hold bit that is set at reset and stays set until the processor clears it;
- a force bit that asserts XOFF regardless of the levels.

Top module: `buf_occ_ctrl`

## Requirements
- R1: After reset the controller is in this state:
  - used count 0 and free count NUM_PAGES (64);
  - every occupancy level register equals NUM_PAGES;
  - XOFF low level = NUM_PAGES/8 (8) and XOFF high level = NUM_PAGES/4 (16);
  - control register = 1 (hold set, force clear) and xoff_o = 1.
- R2: The used count changes on the clock edge where a strobe is high:
  - page_alloc_i alone adds one;
  - page_free_i alone subtracts one;
  - both together, or neither, leave the count unchanged.
- R3: The used count saturates. An allocation at NUM_PAGES is ignored, and a release at 0 is ignored.
- R4: Status bit k (register 8 bit k, and level_hit_o[k]) is 1 exactly when used count >= occupancy level k. It follows the current count and levels with no extra cycle of delay.
- R5: The automatic throttle asserts on the clock edge after the free count falls to or below the XOFF low level.
- R6: The automatic throttle releases on the clock edge after the free count rises above the XOFF high level. Between the two levels it keeps its previous value.
- R7: Control bit 0 (hold) forces xoff_o high. It is 1 from reset and is cleared by writing 0 to it.
- R8: Control bit 1 (force) drives xoff_o high whenever it is set, whatever the free count. xoff_o is the OR of hold, force and the automatic throttle.
- R9: The register map is:
  - addresses 0..NUM_LEVELS-1 hold the occupancy levels;
  - NUM_LEVELS holds the XOFF low level and NUM_LEVELS+1 the XOFF high level;
  - NUM_LEVELS+2 is control ({force, hold});
  - NUM_LEVELS+3 is status (read-only);
  - NUM_LEVELS+4 is the used count (read-only);
  - NUM_LEVELS+5 is the free count (read-only).

  Writes to read-only or unmapped addresses change nothing, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| page_alloc_i | input | 1 | A page moved from the free list to the used queue |
| page_free_i | input | 1 | A used page returned to the free list |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (4) | Register address |
| reg_wdata_i | input | DATA_W (8) | Register write data |
| reg_rdata_o | output | DATA_W (8) | Register read data, combinational from the address |
| level_hit_o | output | NUM_LEVELS (5) | Per-level status: used count at or above that level |
| xoff_o | output | 1 | Throttle to the upstream source |

## Verification
The hardest case to reach is the hysteresis band, together with the one-cycle lag of the automatic throttle. The bench has to walk the buffer almost full, one page at a time. It then observes that XOFF is still low on the edge that brings the free count down to the low level, and high one edge later. It then drains pages back into the band and checks that XOFF holds. Releasing one page past the high level must drop XOFF. The hold bit has to be cleared first, because otherwise it masks all of this.

// File: rtl/buf_occ_pkg.sv
package buf_occ_pkg;
  typedef struct packed {
    logic force_on;
    logic hold;
  } ctrl_t;
endpackage

// File: rtl/boc_occ_counter.sv
module boc_occ_counter #(
  parameter int NUM_PAGES = 64,
  parameter int CNT_W     = $clog2(NUM_PAGES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] used_o,
  output logic [CNT_W-1:0] free_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_PAGES);

  logic [CNT_W-1:0] used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) used_q <= '0;
    else if (inc_i && !dec_i && used_q != FULL) used_q <= used_q + 1'b1;
    else if (dec_i && !inc_i && used_q != '0)   used_q <= used_q - 1'b1;
  end

  assign used_o = used_q;
  assign free_o = FULL - used_q;

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_q <= FULL);
  a_r2_both_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i) |=> $stable(used_q));
  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_q == '0 && !inc_i) |=> used_q == '0);
endmodule

// File: rtl/boc_level_bank.sv
module boc_level_bank #(
  parameter int NUM_LEVELS = 5,
  parameter int CNT_W      = 7
) (
  input  logic [CNT_W-1:0]                 used_i,
  input  logic [NUM_LEVELS-1:0][CNT_W-1:0] lvl_i,
  output logic [NUM_LEVELS-1:0]            hit_o
);
  for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_cmp
    assign hit_o[k] = (used_i >= lvl_i[k]);
  end
endmodule

// File: rtl/boc_xoff_ctrl.sv
module boc_xoff_ctrl #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] free_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic             hold_i,
  input  logic             force_i,
  output logic             xoff_o
);
  logic auto_q;

  // low level wins if levels are misconfigured
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              auto_q <= 1'b0;
    else if (free_i <= lo_i)  auto_q <= 1'b1;
    else if (free_i > hi_i)   auto_q <= 1'b0;
  end

  assign xoff_o = hold_i | force_i | auto_q;

  a_r5_low_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_i <= lo_i) |=> xoff_o);
  a_r6_high_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_i > hi_i && free_i > lo_i) |=> (!xoff_o || hold_i || force_i));
  a_r6_band_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_i > lo_i && free_i <= hi_i) |=> $stable(auto_q));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> xoff_o);
  a_r8_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |-> xoff_o);
endmodule

// File: rtl/buf_occ_ctrl.sv
module buf_occ_ctrl
  import buf_occ_pkg::*;
#(
  parameter int NUM_PAGES  = 64,
  parameter int NUM_LEVELS = 5,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  page_alloc_i,
  input  logic                  page_free_i,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic [NUM_LEVELS-1:0] level_hit_o,
  output logic                  xoff_o
);
  localparam int CNT_W = $clog2(NUM_PAGES + 1);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(NUM_LEVELS);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(NUM_LEVELS + 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NUM_LEVELS + 2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_LEVELS + 3);
  localparam logic [ADDR_W-1:0] A_USED = ADDR_W'(NUM_LEVELS + 4);
  localparam logic [ADDR_W-1:0] A_FREE = ADDR_W'(NUM_LEVELS + 5);
  localparam logic [CNT_W-1:0]  LVL_RST = CNT_W'(NUM_PAGES);
  localparam logic [CNT_W-1:0]  LO_RST  = CNT_W'(NUM_PAGES / 8);
  localparam logic [CNT_W-1:0]  HI_RST  = CNT_W'(NUM_PAGES / 4);

  logic [NUM_LEVELS-1:0][CNT_W-1:0] lvl_q;
  logic [CNT_W-1:0] lo_q, hi_q, used_w, free_w;
  ctrl_t            ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_LEVELS; k++) lvl_q[k] <= LVL_RST;
      lo_q   <= LO_RST;
      hi_q   <= HI_RST;
      ctrl_q <= '{force_on: 1'b0, hold: 1'b1};
    end else if (reg_we_i) begin
      for (int k = 0; k < NUM_LEVELS; k++)
        if (reg_addr_i == ADDR_W'(k)) lvl_q[k] <= reg_wdata_i[CNT_W-1:0];
      if (reg_addr_i == A_LO)   lo_q   <= reg_wdata_i[CNT_W-1:0];
      if (reg_addr_i == A_HI)   hi_q   <= reg_wdata_i[CNT_W-1:0];
      if (reg_addr_i == A_CTRL) ctrl_q <= ctrl_t'(reg_wdata_i[1:0]);
    end
  end

  boc_occ_counter #(.NUM_PAGES(NUM_PAGES), .CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(page_alloc_i), .dec_i(page_free_i),
    .used_o(used_w), .free_o(free_w));

  boc_level_bank #(.NUM_LEVELS(NUM_LEVELS), .CNT_W(CNT_W)) u_lvl (
    .used_i(used_w), .lvl_i(lvl_q), .hit_o(level_hit_o));

  boc_xoff_ctrl #(.CNT_W(CNT_W)) u_xoff (
    .clk_i(clk_i), .rst_ni(rst_ni), .free_i(free_w), .lo_i(lo_q), .hi_i(hi_q),
    .hold_i(ctrl_q.hold), .force_i(ctrl_q.force_on), .xoff_o(xoff_o));

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < NUM_LEVELS; k++)
      if (reg_addr_i == ADDR_W'(k)) reg_rdata_o = DATA_W'(lvl_q[k]);
    if (reg_addr_i == A_LO)   reg_rdata_o = DATA_W'(lo_q);
    if (reg_addr_i == A_HI)   reg_rdata_o = DATA_W'(hi_q);
    if (reg_addr_i == A_CTRL) reg_rdata_o = DATA_W'(ctrl_q);
    if (reg_addr_i == A_STAT) reg_rdata_o = DATA_W'(level_hit_o);
    if (reg_addr_i == A_USED) reg_rdata_o = DATA_W'(used_w);
    if (reg_addr_i == A_FREE) reg_rdata_o = DATA_W'(free_w);
  end

  a_r9_ro_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i >= A_STAT) |=> ($stable(lo_q) && $stable(hi_q) && $stable(ctrl_q)));
  a_r7_hold_clear_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q.hold) |-> $past(reg_we_i && reg_addr_i == A_CTRL));
endmodule

// File: tb/tb_buf_occ_ctrl.sv
`timescale 1ns/1ps
module tb_buf_occ_ctrl;
  localparam int NP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc = 1'b0, rel = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [4:0] hit;
  logic xoff;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  buf_occ_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .page_alloc_i(alloc), .page_free_i(rel),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .level_hit_o(hit), .xoff_o(xoff));

  // {alloc, release, expected used count after the edge}
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 1'b1, 7'd0}, {1'b1, 1'b0, 7'd1}, {1'b1, 1'b0, 7'd2}, {1'b1, 1'b1, 7'd2},
    {1'b0, 1'b1, 7'd1}, {1'b1, 1'b0, 7'd2}, {1'b0, 1'b0, 7'd2}, {1'b1, 1'b1, 7'd2}};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input int a, input int exp);
    addr = 4'(a);
    #1;
    chk(req, int'(rdata), exp);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse(input bit is_alloc, input int n);
    @(negedge clk);
    if (is_alloc) alloc = 1'b1; else rel = 1'b1;
    repeat (n) @(negedge clk);
    alloc = 1'b0; rel = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    rd("R1 used", 9, 0);
    rd("R1 free", 10, NP);
    rd("R1 level0", 0, NP);
    rd("R1 level4", 4, NP);
    rd("R1 xoff low", 5, 8);
    rd("R1 xoff high", 6, 16);
    rd("R1 ctrl", 7, 1);
    chk("R1 xoff", int'(xoff), 1);
    chk("R1 hits", int'(hit), 0);

    // R2/R3 vector walk
    foreach (VEC[i]) begin
      @(negedge clk);
      alloc = VEC[i][8]; rel = VEC[i][7];
      @(negedge clk);
      alloc = 1'b0; rel = 1'b0;
      rd("R2 vector used", 9, int'(VEC[i][6:0]));
      rd("R2 vector free", 10, NP - int'(VEC[i][6:0]));
    end

    // R7 clearing hold drops xoff (free 62 above high level)
    chk("R7 hold before clear", int'(xoff), 1);
    wr(7, 0);
    chk("R7 xoff after hold cleared", int'(xoff), 0);

    // R5 low-level crossing with one-cycle lag
    pulse(1'b1, 53);
    @(negedge clk);
    rd("R5 used 55", 9, 55);
    chk("R5 free 9 no xoff", int'(xoff), 0);
    pulse(1'b1, 1);
    chk("R5 xoff lags one edge", int'(xoff), 0);
    @(negedge clk);
    chk("R5 xoff at free 8", int'(xoff), 1);

    // R6 hysteresis band then release
    pulse(1'b0, 8);
    @(negedge clk);
    rd("R6 free 16", 10, 16);
    chk("R6 xoff held in band", int'(xoff), 1);
    pulse(1'b0, 1);
    @(negedge clk);
    chk("R6 xoff released at free 17", int'(xoff), 0);

    // R4 levels 10,20,30,40,50 at used 47
    for (int k = 0; k < 5; k++) wr(k, 10 * (k + 1));
    rd("R4 status used 47", 8, 5'h0F);
    chk("R4 hit port", int'(hit), 5'h0F);
    pulse(1'b1, 3);
    rd("R4 status used 50", 8, 5'h1F);
    pulse(1'b0, 1);
    rd("R4 status used 49", 8, 5'h0F);
    pulse(1'b1, 1);
    chk("R6 band keeps xoff low", int'(xoff), 0);

    // R8 force
    wr(7, 2);
    chk("R8 force on", int'(xoff), 1);
    rd("R8 ctrl read", 7, 2);
    wr(7, 0);
    chk("R8 force off", int'(xoff), 0);

    // R9 ignored writes
    wr(12, 8'hFF);
    rd("R9 ctrl untouched", 7, 0);
    rd("R9 level0 untouched", 0, 10);
    rd("R9 unmapped reads 0", 12, 0);
    chk("R9 xoff untouched", int'(xoff), 0);
    wr(9, 0);
    rd("R9 used read-only", 9, 50);
    wr(8, 0);
    rd("R9 status read-only", 8, 5'h1F);

    // R3 saturation at full and empty
    pulse(1'b1, 20);
    rd("R3 saturate full", 9, NP);
    rd("R3 free zero", 10, 0);
    pulse(1'b1, 1);
    rd("R3 alloc at full ignored", 9, NP);
    pulse(1'b0, 70);
    rd("R3 saturate empty", 9, 0);
    rd("R3 free full", 10, NP);

    // R7 hold set again by write
    wr(7, 1);
    chk("R7 hold rewritten", int'(xoff), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule